// File: doc/BRIEF.md
# Debug Mode Entry Controller

This block sits beside the instruction sequencer of a processor core. In every cycle it looks at three requests: an external hardware breakpoint, a decode strobe with the current instruction word, and a double bus fault report that carries a 16-bit status word. A configuration bit says whether debug mode is on. When it is on, the winning request halts the core into debug mode. FREEZE rises, instruction issue is stalled, and a 32-bit scratch register records which source caused the entry. The serial command path is enabled one cycle after FREEZE.

When debug mode is off, each source has its own fallback. A breakpoint raises an exception with vector number 0x0C. The reserved debug opcode raises an illegal-instruction trap. A double bus fault halts the core until reset. A double bus fault that occurs during the initial stack-pointer and program-counter fetch also loads the all-ones value into the current-instruction PC. The scratch register can always be read, so a register-read debug command can return it. A resume pulse leaves debug mode.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: With `dbg_en` high, a breakpoint request in the run state sets `freeze_o` and `stall_o` on the next cycle and loads `treg_o` with 0x00000000.
- R2: With `dbg_en` low, a breakpoint request in the run state pulses `exc_req_o` for exactly one cycle, with `exc_vec_o` = 0x0C during the pulse and 0x00 otherwise.
- R3: With `dbg_en` high, `dec_valid_i` high with `dec_opcode_i` = 0x4AFA enters debug mode and loads `treg_o` with 0x00000001. Any other opcode, or the value 0x4AFA with `dec_valid_i` low, has no effect.
- R4: With `dbg_en` low, a valid opcode 0x4AFA pulses `illegal_trap_o` for one cycle and does not freeze.
- R5: With `dbg_en` high, a double bus fault enters debug mode and loads `treg_o` with the status word in bits 31..16 and 0xFFFF in bits 15..0.
- R6: With `dbg_en` low, a double bus fault sets `halt_o` and `stall_o`. Both stay high until reset, and resume and all requests are ignored in that state.
- R7: When several requests arrive in one cycle, only the winner acts. The double bus fault wins over the breakpoint, and the breakpoint wins over the debug opcode.
- R8: `serial_en_o` rises one cycle after `freeze_o` and falls together with it.
- R9: A `resume_i` pulse while frozen clears `freeze_o`, `stall_o` and `serial_en_o` on the next cycle. A resume pulse in the run state has no effect.
- R10: While frozen, all requests are ignored. `treg_o` keeps its value and no exception or trap is raised.
- R11: A double bus fault with `dbf_init_i` high, in the run state, pulses `pc_load_o` for one cycle with `pc_value_o` = 0xFFFFFFFF, whatever the value of `dbg_en`. At no other time is `pc_load_o` high.
- R12: After reset all outputs are low, except `pc_value_o`, and `treg_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_en | input | 1 | Debug mode enabled |
| bkpt_i | input | 1 | Acknowledged hardware breakpoint |
| dec_valid_i | input | 1 | Decode strobe |
| dec_opcode_i | input | 16 | Instruction word being decoded |
| dbf_i | input | 1 | Double bus fault report |
| dbf_ssw_i | input | 16 | Status word of the faulting access |
| dbf_init_i | input | 1 | Fault occurred during the initial SP/PC fetch |
| resume_i | input | 1 | Leave debug mode |
| freeze_o | output | 1 | Core is in debug mode |
| stall_o | output | 1 | Instruction issue stalled |
| serial_en_o | output | 1 | Serial command path enabled |
| halt_o | output | 1 | Core halted by a double bus fault |
| exc_req_o | output | 1 | Breakpoint exception request |
| exc_vec_o | output | 8 | Exception vector number |
| illegal_trap_o | output | 1 | Illegal-instruction trap request |
| pc_load_o | output | 1 | Load the current-instruction PC |
| pc_value_o | output | 32 | Value for the PC load |
| treg_o | output | 32 | Entry-source scratch register |

## Verification
If the state register is wrong, the error shows one cycle after the request. FREEZE, halt or a fallback pulse appears where another was due, or a later request is acted on while frozen. A wrong entry code shows at once on `treg_o`. It persists until the next entry, so the bench reads it right after the entry and again after ignored requests. A broken priority shows as the wrong code or the wrong fallback when several requests arrive in the same cycle.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_DBF  = 2'd1,
        SRC_BKPT = 2'd2,
        SRC_SWI  = 2'd3
    } dbg_src_e;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_FRZ  = 2'd1,
        ST_HALT = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/dbg_src_arb.sv
module dbg_src_arb
    import dbg_entry_pkg::*;
#(
    parameter int OPC_W = 16,
    parameter int SSW_W = 16,
    parameter logic [OPC_W-1:0] SWI_OPCODE = 16'h4AFA,
    localparam int TREG_W = 2 * SSW_W
) (
    input  logic              bkpt_i,
    input  logic              dec_valid_i,
    input  logic [OPC_W-1:0]  dec_opcode_i,
    input  logic              dbf_i,
    input  logic [SSW_W-1:0]  dbf_ssw_i,
    input  logic              dbf_init_i,
    output dbg_src_e          src_o,
    output logic [TREG_W-1:0] code_o,
    output logic              init_fault_o
);
    logic swi_hit;

    assign swi_hit      = dec_valid_i && (dec_opcode_i == SWI_OPCODE);
    assign init_fault_o = dbf_i && dbf_init_i;

    // Fixed priority: fault, then breakpoint, then debug opcode.
    always_comb begin
        src_o  = SRC_NONE;
        code_o = '0;
        if (dbf_i) begin
            src_o  = SRC_DBF;
            code_o = {dbf_ssw_i, {SSW_W{1'b1}}};
        end else if (bkpt_i) begin
            src_o  = SRC_BKPT;
            code_o = '0;
        end else if (swi_hit) begin
            src_o  = SRC_SWI;
            code_o = TREG_W'(1);
        end
    end
endmodule

// File: rtl/dbg_ctl_fsm.sv
module dbg_ctl_fsm
    import dbg_entry_pkg::*;
#(
    parameter int TREG_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_en,
    input  dbg_src_e          src_i,
    input  logic [TREG_W-1:0] code_i,
    input  logic              init_fault_i,
    input  logic              resume_i,
    output logic              freeze_o,
    output logic              stall_o,
    output logic              serial_en_o,
    output logic              halt_o,
    output logic              exc_o,
    output logic              ill_o,
    output logic              pc_load_o,
    output logic [TREG_W-1:0] treg_o
);
    typedef struct packed {
        ctl_state_e        st;
        logic              ser;
        logic [TREG_W-1:0] treg;
        logic              exc;
        logic              ill;
        logic              pcl;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.exc = 1'b0;
        r_d.ill = 1'b0;
        r_d.pcl = 1'b0;
        unique case (r_q.st)
            ST_RUN: begin
                r_d.pcl = init_fault_i;
                unique case (src_i)
                    SRC_DBF: begin
                        if (dbg_en) begin
                            r_d.st   = ST_FRZ;
                            r_d.treg = code_i;
                        end else begin
                            r_d.st = ST_HALT;
                        end
                    end
                    SRC_BKPT: begin
                        if (dbg_en) begin
                            r_d.st   = ST_FRZ;
                            r_d.treg = code_i;
                        end else begin
                            r_d.exc = 1'b1;
                        end
                    end
                    SRC_SWI: begin
                        if (dbg_en) begin
                            r_d.st   = ST_FRZ;
                            r_d.treg = code_i;
                        end else begin
                            r_d.ill = 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
            ST_FRZ: begin
                if (resume_i) begin
                    r_d.st  = ST_RUN;
                    r_d.ser = 1'b0;
                end else begin
                    r_d.ser = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_RUN, ser: 1'b0, treg: '0, exc: 1'b0, ill: 1'b0, pcl: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign freeze_o    = (r_q.st == ST_FRZ);
    assign halt_o      = (r_q.st == ST_HALT);
    assign stall_o     = (r_q.st != ST_RUN);
    assign serial_en_o = r_q.ser;
    assign exc_o       = r_q.exc;
    assign ill_o       = r_q.ill;
    assign pc_load_o   = r_q.pcl;
    assign treg_o      = r_q.treg;

    // R8: serial path only while frozen, never in the first frozen cycle
    assert_ser_in_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        serial_en_o |-> freeze_o);
    assert_ser_lags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(serial_en_o) |-> $past(freeze_o));
    // R2: exception request is a single-cycle pulse
    assert_exc_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        exc_o |=> !exc_o);
    // R6: halt persists until reset
    assert_halt_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |=> halt_o);
    // R10: scratch register stable while frozen and not resuming
    assert_treg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_o && !resume_i) |=> $stable(treg_o));
    // R11: PC load only after an initial-fetch fault in the run state
    assert_pc_load_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |-> $past(init_fault_i));
    // R7: at most one fallback per cycle
    assert_one_fallback_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({exc_o, ill_o}));
endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
    import dbg_entry_pkg::*;
#(
    parameter int OPC_W = 16,
    parameter int SSW_W = 16,
    parameter int VEC_W = 8,
    parameter logic [VEC_W-1:0] BKPT_VEC = 8'h0C,
    parameter logic [OPC_W-1:0] SWI_OPCODE = 16'h4AFA,
    localparam int TREG_W = 2 * SSW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_en,
    input  logic              bkpt_i,
    input  logic              dec_valid_i,
    input  logic [OPC_W-1:0]  dec_opcode_i,
    input  logic              dbf_i,
    input  logic [SSW_W-1:0]  dbf_ssw_i,
    input  logic              dbf_init_i,
    input  logic              resume_i,
    output logic              freeze_o,
    output logic              stall_o,
    output logic              serial_en_o,
    output logic              halt_o,
    output logic              exc_req_o,
    output logic [VEC_W-1:0]  exc_vec_o,
    output logic              illegal_trap_o,
    output logic              pc_load_o,
    output logic [TREG_W-1:0] pc_value_o,
    output logic [TREG_W-1:0] treg_o
);
    dbg_src_e          src;
    logic [TREG_W-1:0] code;
    logic              init_fault;

    dbg_src_arb #(
        .OPC_W(OPC_W), .SSW_W(SSW_W), .SWI_OPCODE(SWI_OPCODE)
    ) i_arb (
        .bkpt_i(bkpt_i), .dec_valid_i(dec_valid_i), .dec_opcode_i(dec_opcode_i),
        .dbf_i(dbf_i), .dbf_ssw_i(dbf_ssw_i), .dbf_init_i(dbf_init_i),
        .src_o(src), .code_o(code), .init_fault_o(init_fault)
    );

    dbg_ctl_fsm #(
        .TREG_W(TREG_W)
    ) i_fsm (
        .clk(clk), .rst_n(rst_n), .dbg_en(dbg_en), .src_i(src), .code_i(code),
        .init_fault_i(init_fault), .resume_i(resume_i),
        .freeze_o(freeze_o), .stall_o(stall_o), .serial_en_o(serial_en_o),
        .halt_o(halt_o), .exc_o(exc_req_o), .ill_o(illegal_trap_o),
        .pc_load_o(pc_load_o), .treg_o(treg_o)
    );

    assign exc_vec_o  = exc_req_o ? BKPT_VEC : '0;
    assign pc_value_o = '1;
endmodule

// File: tb/test_dbg_entry_ctrl.sv
module test_dbg_entry_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbg_en = 1'b0, bkpt_i = 1'b0, dec_valid_i = 1'b0, dbf_i = 1'b0;
    logic        dbf_init_i = 1'b0, resume_i = 1'b0;
    logic [15:0] dec_opcode_i = '0, dbf_ssw_i = '0;
    logic        freeze_o, stall_o, serial_en_o, halt_o, exc_req_o, illegal_trap_o, pc_load_o;
    logic [7:0]  exc_vec_o;
    logic [31:0] pc_value_o, treg_o;

    int n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    dbg_entry_ctrl i_dbg_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .dbg_en(dbg_en), .bkpt_i(bkpt_i),
        .dec_valid_i(dec_valid_i), .dec_opcode_i(dec_opcode_i), .dbf_i(dbf_i),
        .dbf_ssw_i(dbf_ssw_i), .dbf_init_i(dbf_init_i), .resume_i(resume_i),
        .freeze_o(freeze_o), .stall_o(stall_o), .serial_en_o(serial_en_o),
        .halt_o(halt_o), .exc_req_o(exc_req_o), .exc_vec_o(exc_vec_o),
        .illegal_trap_o(illegal_trap_o), .pc_load_o(pc_load_o),
        .pc_value_o(pc_value_o), .treg_o(treg_o)
    );

    typedef struct packed {
        logic        en, bk, dv;
        logic [15:0] op;
        logic        dbf;
        logic [15:0] ssw;
        logic        ini;
        logic        e_frz;
        logic [31:0] e_treg;
        logic        e_exc, e_ill, e_halt, e_pcl;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b1,1'b0,16'h0000,1'b0,16'h0000,1'b0, 1'b1,32'h00000000,1'b0,1'b0,1'b0,1'b0}, // R1
        '{1'b1,1'b0,1'b1,16'h4AFA,1'b0,16'h0000,1'b0, 1'b1,32'h00000001,1'b0,1'b0,1'b0,1'b0}, // R3
        '{1'b1,1'b0,1'b0,16'h0000,1'b1,16'hA5C3,1'b0, 1'b1,32'hA5C3FFFF,1'b0,1'b0,1'b0,1'b0}, // R5
        '{1'b0,1'b1,1'b0,16'h0000,1'b0,16'h0000,1'b0, 1'b0,32'h00000000,1'b1,1'b0,1'b0,1'b0}, // R2
        '{1'b0,1'b0,1'b1,16'h4AFA,1'b0,16'h0000,1'b0, 1'b0,32'h00000000,1'b0,1'b1,1'b0,1'b0}, // R4
        '{1'b0,1'b0,1'b0,16'h0000,1'b1,16'h7777,1'b0, 1'b0,32'h00000000,1'b0,1'b0,1'b1,1'b0}, // R6
        '{1'b1,1'b0,1'b1,16'h4AFB,1'b0,16'h0000,1'b0, 1'b0,32'h00000000,1'b0,1'b0,1'b0,1'b0}, // R3 other opcode
        '{1'b1,1'b1,1'b1,16'h4AFA,1'b1,16'h1234,1'b0, 1'b1,32'h1234FFFF,1'b0,1'b0,1'b0,1'b0}, // R7 all three
        '{1'b1,1'b1,1'b1,16'h4AFA,1'b0,16'h0000,1'b0, 1'b1,32'h00000000,1'b0,1'b0,1'b0,1'b0}, // R7 bkpt over opcode
        '{1'b0,1'b1,1'b1,16'h4AFA,1'b0,16'h0000,1'b0, 1'b0,32'h00000000,1'b1,1'b0,1'b0,1'b0}, // R7 fallback
        '{1'b1,1'b0,1'b0,16'h0000,1'b1,16'h0000,1'b1, 1'b1,32'h0000FFFF,1'b0,1'b0,1'b0,1'b1}, // R11 enabled
        '{1'b0,1'b1,1'b0,16'h0000,1'b1,16'h0000,1'b1, 1'b0,32'h00000000,1'b0,1'b0,1'b1,1'b1}, // R11 disabled, R7
        '{1'b1,1'b0,1'b0,16'h4AFA,1'b0,16'h0000,1'b0, 1'b0,32'h00000000,1'b0,1'b0,1'b0,1'b0}  // R3 no strobe
    };

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic clear_in();
        dbg_en = 1'b0; bkpt_i = 1'b0; dec_valid_i = 1'b0; dec_opcode_i = '0;
        dbf_i = 1'b0; dbf_ssw_i = '0; dbf_init_i = 1'b0; resume_i = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        clear_in();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        // R12: reset state
        do_reset();
        chk("R12", "freeze", {31'b0, freeze_o}, 0);
        chk("R12", "stall", {31'b0, stall_o}, 0);
        chk("R12", "serial", {31'b0, serial_en_o}, 0);
        chk("R12", "halt", {31'b0, halt_o}, 0);
        chk("R12", "exc", {31'b0, exc_req_o}, 0);
        chk("R12", "pc_load", {31'b0, pc_load_o}, 0);
        chk("R12", "treg", treg_o, 0);

        for (int i = 0; i < NV; i++) begin
            do_reset();
            dbg_en = VECS[i].en; bkpt_i = VECS[i].bk; dec_valid_i = VECS[i].dv;
            dec_opcode_i = VECS[i].op; dbf_i = VECS[i].dbf; dbf_ssw_i = VECS[i].ssw;
            dbf_init_i = VECS[i].ini;
            tick();
            clear_in();
            chk($sformatf("vector %0d", i), "freeze", {31'b0, freeze_o}, {31'b0, VECS[i].e_frz});
            chk($sformatf("vector %0d", i), "treg", treg_o, VECS[i].e_treg);
            chk($sformatf("vector %0d", i), "exc", {31'b0, exc_req_o}, {31'b0, VECS[i].e_exc});
            chk($sformatf("vector %0d", i), "trap", {31'b0, illegal_trap_o}, {31'b0, VECS[i].e_ill});
            chk($sformatf("vector %0d", i), "halt", {31'b0, halt_o}, {31'b0, VECS[i].e_halt});
            chk($sformatf("vector %0d", i), "pc_load", {31'b0, pc_load_o}, {31'b0, VECS[i].e_pcl});
            if (VECS[i].e_pcl)
                chk("R11", "pc_value", pc_value_o, 32'hFFFFFFFF);
            if (VECS[i].e_exc)
                chk("R2", "vector", {24'b0, exc_vec_o}, 32'h0C);
            tick();
            chk("R2", "pulse ends", {31'b0, exc_req_o}, 0);
            chk("R4", "pulse ends", {31'b0, illegal_trap_o}, 0);
            chk("R11", "pulse ends", {31'b0, pc_load_o}, 0);
        end

        // R8: serial path lags freeze by one cycle
        do_reset();
        dbg_en = 1'b1; dec_valid_i = 1'b1; dec_opcode_i = 16'h4AFA;
        tick();
        clear_in(); dbg_en = 1'b1;
        chk("R8", "freeze", {31'b0, freeze_o}, 1);
        chk("R8", "stall", {31'b0, stall_o}, 1);
        chk("R8", "serial first cycle", {31'b0, serial_en_o}, 0);
        // R10: requests while frozen are ignored
        dbf_i = 1'b1; dbf_ssw_i = 16'hBEEF; bkpt_i = 1'b1;
        tick();
        chk("R8", "serial second cycle", {31'b0, serial_en_o}, 1);
        dbf_i = 1'b0; bkpt_i = 1'b1; dbg_en = 1'b0;
        tick();
        clear_in();
        chk("R10", "treg kept", treg_o, 32'h00000001);
        chk("R10", "no exc", {31'b0, exc_req_o}, 0);
        chk("R10", "no halt", {31'b0, halt_o}, 0);
        chk("R10", "still frozen", {31'b0, freeze_o}, 1);
        // R9: resume clears everything
        resume_i = 1'b1;
        tick();
        resume_i = 1'b0;
        chk("R9", "freeze cleared", {31'b0, freeze_o}, 0);
        chk("R9", "stall cleared", {31'b0, stall_o}, 0);
        chk("R8", "serial cleared", {31'b0, serial_en_o}, 0);
        chk("R9", "treg after resume", treg_o, 32'h00000001);
        // R9: resume while running has no effect
        resume_i = 1'b1;
        tick();
        resume_i = 1'b0;
        chk("R9", "idle resume", {31'b0, freeze_o | stall_o}, 0);
        // R1: breakpoint after an opcode entry rewrites code to zero
        dbg_en = 1'b1; bkpt_i = 1'b1;
        tick();
        clear_in();
        chk("R1", "freeze", {31'b0, freeze_o}, 1);
        chk("R1", "treg", treg_o, 0);

        // R6: halt is sticky and ignores resume and requests
        do_reset();
        dbf_i = 1'b1;
        tick();
        clear_in();
        chk("R6", "halt", {31'b0, halt_o}, 1);
        chk("R6", "stall", {31'b0, stall_o}, 1);
        resume_i = 1'b1; dbg_en = 1'b1; bkpt_i = 1'b1;
        tick();
        clear_in();
        tick();
        chk("R6", "halt kept", {31'b0, halt_o}, 1);
        chk("R6", "no freeze", {31'b0, freeze_o}, 0);
        chk("R6", "treg kept", treg_o, 0);
        do_reset();
        chk("R12", "halt cleared", {31'b0, halt_o}, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule